// File: doc/BRIEF.md
# Dual 16-bit Signed Multiply-Accumulate Unit

This datapath block takes two 32-bit operand words. Each word holds a pair of signed 16-bit halves. The block forms the two halfword products: low half times low half, and high half times high half. Before multiplying, it can exchange the two halves of the second operand. It then adds the second product to the first, or subtracts it from the first. The combined value can go through a 64-bit path, with an optional 64-bit accumulator. It can instead go through a 32-bit path, with an optional 32-bit accumulator and a signed-overflow indication.

The 64-bit path sign-extends each product to the full width before any combining. A pair of large positive products therefore yields a large positive total, never a wrapped negative one. The overflow indication (Q) is computed only on the 32-bit path. It is raised when the 32-bit product sum overflows, or when the accumulation that follows it overflows. The surrounding pipeline keeps any sticky copy of it.

One operation is accepted on each cycle in which `in_valid` is high. The result appears on the registered outputs on the next cycle, together with a one-cycle `out_valid` pulse.

Top module: `dmac_dual16`

## Requirements
- R1: When `swap_b` is 1, `op_b` is rotated by 16 bits (its halves exchanged) before multiplication. When it is 0, `op_b` is used unchanged.
- R2: Product 1 is `op_a[15:0]` times `op_b'[15:0]`, and product 2 is `op_a[31:16]` times `op_b'[31:16]`. All four halves are treated as signed two's complement. `op_b'` is `op_b` after the optional swap.
- R3: With `long_mode` = 1, the result is computed in 64-bit signed arithmetic from the products, each sign-extended first. Two products of 0x40000000 give {`res_hi`,`res_lo`} = 0x00000000_80000000.
- R4: `sub_mode` = 0 selects product1 + product2, and `sub_mode` = 1 selects product1 − product2, in both modes.
- R5: With `long_mode` = 1 and `acc_en` = 1, the signed 64-bit value {`acc_hi`,`acc_lo`} is added. With `acc_en` = 0 the accumulator inputs have no effect. Result bits 63:32 go on `res_hi` and bits 31:0 on `res_lo`.
- R6: With `long_mode` = 1, `q_flag` is 0 for that result, whether adding or subtracting.
- R7: With `long_mode` = 0 and `sub_mode` = 0, the product sum is taken modulo 2^32. `q_flag` is 1 when the true sum lies outside the signed 32-bit range.
- R8: With `long_mode` = 0 and `sub_mode` = 1, the difference cannot overflow. With `acc_en` = 0 as well, `q_flag` is 0.
- R9: With `long_mode` = 0 and `acc_en` = 1, the signed 32-bit `acc_lo` is added modulo 2^32 to the wrapped 32-bit combination, and `acc_hi` has no effect. `q_flag` is also raised when this addition overflows as signed.
- R10: With `long_mode` = 0, `res_lo` carries the 32-bit result and every bit of `res_hi` equals `res_lo[31]`.
- R11: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. The results and `q_flag` belong to the operation captured on that edge.
- R12: Reset (`rst_n` low) clears `out_valid`, `q_flag`, `res_hi` and `res_lo` to 0. On a clock edge with `in_valid` low, `res_hi`, `res_lo` and `q_flag` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture an operation on this edge |
| op_a | input | 32 | Packed signed halves, first operand |
| op_b | input | 32 | Packed signed halves, second operand |
| acc_hi | input | 32 | Accumulator bits 63:32 (long mode only) |
| acc_lo | input | 32 | Accumulator bits 31:0, or the 32-bit accumulator in short mode |
| swap_b | input | 1 | Exchange the halves of op_b |
| sub_mode | input | 1 | 0: add products, 1: subtract product 2 |
| long_mode | input | 1 | 1: 64-bit path, 0: 32-bit path |
| acc_en | input | 1 | Add the accumulator |
| out_valid | output | 1 | One-cycle result strobe |
| res_hi | output | 32 | Result bits 63:32, or the sign fill in short mode |
| res_lo | output | 32 | Result bits 31:0 |
| q_flag | output | 1 | Signed overflow on the 32-bit path |

## Verification
The bench drives 0x8000 × 0x8000 in both lanes. That case gives the largest positive product and the exact 2^31 product sum. A design that extends only after summing would return a negative 64-bit total there, and a design missing the overflow test would leave Q low in short add mode. Asymmetric operands under both swap settings expose a lane mix-up or a swap with no effect. Long and short subtraction at the extremes, plus accumulators that push the 32-bit sum across the sign boundary, catch a Q that leaks into long or subtract mode or that ignores the accumulation step. Idle gaps between operations check that the outputs hold and that the strobe lasts exactly one cycle.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    // Default width of one packed signed lane.
    parameter int unsigned DEFAULT_HALF_W = 16;

    // Lane count per operand word.
    parameter int unsigned LANES = 2;

    // How the two lane products are combined.
    typedef enum logic {
        COMB_ADD = 1'b0,
        COMB_SUB = 1'b1
    } comb_op_e;

    // Result path selection.
    typedef enum logic {
        PATH_SHORT = 1'b0,
        PATH_LONG  = 1'b1
    } path_e;

endpackage

// File: rtl/dmac_lane_mul.sv
module dmac_lane_mul
    import dmac_pkg::*;
#(
    parameter int unsigned HALF_W = DEFAULT_HALF_W
) (
    input  logic [2*HALF_W-1:0]             word_a,
    input  logic [2*HALF_W-1:0]             word_b,
    input  logic                            swap_b,
    output logic [LANES-1:0][2*HALF_W-1:0]  prods
);
    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned PROD_W = 2 * HALF_W;

    logic [WORD_W-1:0] b_sel;

    // Exchange halves of the second operand when requested.
    always_comb begin
        if (swap_b) begin
            b_sel = {word_b[HALF_W-1:0], word_b[WORD_W-1:HALF_W]};
        end else begin
            b_sel = word_b;
        end
    end

    // One signed multiplier per lane.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic signed [HALF_W-1:0] a_h;
        logic signed [HALF_W-1:0] b_h;
        logic signed [PROD_W-1:0] p;

        always_comb begin
            a_h = word_a[ln*HALF_W +: HALF_W];
            b_h = b_sel[ln*HALF_W +: HALF_W];
            p   = PROD_W'(a_h) * PROD_W'(b_h);
        end

        assign prods[ln] = p;
    end

endmodule

// File: rtl/dmac_long_path.sv
module dmac_long_path
    import dmac_pkg::*;
#(
    parameter int unsigned HALF_W = DEFAULT_HALF_W
) (
    input  logic [2*HALF_W-1:0] prod_lo,
    input  logic [2*HALF_W-1:0] prod_hi,
    input  comb_op_e            comb_op,
    input  logic                acc_en,
    input  logic [4*HALF_W-1:0] acc,
    output logic [4*HALF_W-1:0] total
);
    localparam int unsigned PROD_W = 2 * HALF_W;
    localparam int unsigned LONG_W = 4 * HALF_W;
    localparam int unsigned EXT_W  = LONG_W - PROD_W;

    logic [LONG_W-1:0] ext_lo;
    logic [LONG_W-1:0] ext_hi;
    logic [LONG_W-1:0] pair;
    logic [LONG_W-1:0] acc_term;

    always_comb begin
        // Widen each product on its own before they meet.
        ext_lo   = {{EXT_W{prod_lo[PROD_W-1]}}, prod_lo};
        ext_hi   = {{EXT_W{prod_hi[PROD_W-1]}}, prod_hi};
        pair     = (comb_op == COMB_SUB) ? (ext_lo - ext_hi) : (ext_lo + ext_hi);
        acc_term = acc_en ? acc : '0;
        total    = pair + acc_term;
    end

endmodule

// File: rtl/dmac_short_path.sv
module dmac_short_path
    import dmac_pkg::*;
#(
    parameter int unsigned HALF_W = DEFAULT_HALF_W
) (
    input  logic [2*HALF_W-1:0] prod_lo,
    input  logic [2*HALF_W-1:0] prod_hi,
    input  comb_op_e            comb_op,
    input  logic                acc_en,
    input  logic [2*HALF_W-1:0] acc,
    output logic [2*HALF_W-1:0] result,
    output logic                ovf
);
    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned MSB    = WORD_W - 1;

    logic [WORD_W-1:0] pair;
    logic [WORD_W-1:0] with_acc;
    logic              pair_ovf;
    logic              acc_ovf;

    always_comb begin
        if (comb_op == COMB_SUB) begin
            pair     = prod_lo - prod_hi;
            pair_ovf = 1'b0;
        end else begin
            pair     = prod_lo + prod_hi;
            pair_ovf = (prod_lo[MSB] == prod_hi[MSB]) && (pair[MSB] != prod_lo[MSB]);
        end

        with_acc = pair + acc;
        acc_ovf  = acc_en && (pair[MSB] == acc[MSB]) && (with_acc[MSB] != pair[MSB]);

        result = acc_en ? with_acc : pair;
        ovf    = pair_ovf | acc_ovf;
    end

endmodule

// File: rtl/dmac_dual16.sv
module dmac_dual16
    import dmac_pkg::*;
#(
    parameter int unsigned HALF_W = DEFAULT_HALF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2*HALF_W-1:0] op_a,
    input  logic [2*HALF_W-1:0] op_b,
    input  logic [2*HALF_W-1:0] acc_hi,
    input  logic [2*HALF_W-1:0] acc_lo,
    input  logic                swap_b,
    input  logic                sub_mode,
    input  logic                long_mode,
    input  logic                acc_en,
    output logic                out_valid,
    output logic [2*HALF_W-1:0] res_hi,
    output logic [2*HALF_W-1:0] res_lo,
    output logic                q_flag
);
    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned LONG_W = 2 * WORD_W;

    typedef struct packed {
        logic              vld;
        logic              q;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } out_state_t;

    logic [LANES-1:0][WORD_W-1:0] prods;
    logic [LONG_W-1:0]            long_total;
    logic [WORD_W-1:0]            short_res;
    logic                         short_ovf;
    comb_op_e                     comb_op;
    path_e                        path;
    out_state_t                   st_d;
    out_state_t                   st_q;

    assign comb_op = comb_op_e'(sub_mode);
    assign path    = path_e'(long_mode);

    dmac_lane_mul #(.HALF_W(HALF_W)) u_mul (
        .word_a (op_a),
        .word_b (op_b),
        .swap_b (swap_b),
        .prods  (prods)
    );

    dmac_long_path #(.HALF_W(HALF_W)) u_long (
        .prod_lo (prods[0]),
        .prod_hi (prods[1]),
        .comb_op (comb_op),
        .acc_en  (acc_en),
        .acc     ({acc_hi, acc_lo}),
        .total   (long_total)
    );

    dmac_short_path #(.HALF_W(HALF_W)) u_short (
        .prod_lo (prods[0]),
        .prod_hi (prods[1]),
        .comb_op (comb_op),
        .acc_en  (acc_en),
        .acc     (acc_lo),
        .result  (short_res),
        .ovf     (short_ovf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (path == PATH_LONG) begin
                st_d.hi = long_total[LONG_W-1:WORD_W];
                st_d.lo = long_total[WORD_W-1:0];
                st_d.q  = 1'b0;
            end else begin
                st_d.hi = {WORD_W{short_res[WORD_W-1]}};
                st_d.lo = short_res;
                st_d.q  = short_ovf;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign res_hi    = st_q.hi;
    assign res_lo    = st_q.lo;
    assign q_flag    = st_q.q;

endmodule

// File: rtl/dmac_dual16_chk.sv
module dmac_dual16_chk #(
    parameter int unsigned HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                sub_mode,
    input logic                long_mode,
    input logic                acc_en,
    input logic                out_valid,
    input logic [2*HALF_W-1:0] res_hi,
    input logic [2*HALF_W-1:0] res_lo,
    input logic                q_flag
);
    localparam int unsigned WORD_W = 2 * HALF_W;

    AST_STROBE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R11
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R11
    AST_LONG_Q_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && long_mode) |=> !q_flag); // R6
    AST_SHORT_SUB_Q_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !long_mode && sub_mode && !acc_en) |=> !q_flag); // R8
    AST_SHORT_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !long_mode) |=> (res_hi == {WORD_W{res_lo[WORD_W-1]}})); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_hi) && $stable(res_lo) && $stable(q_flag))); // R12

endmodule

bind dmac_dual16 dmac_dual16_chk #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sub_mode  (sub_mode),
    .long_mode (long_mode),
    .acc_en    (acc_en),
    .out_valid (out_valid),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .q_flag    (q_flag)
);

// File: tb/dmac_dual16_test.sv
module dmac_dual16_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] acc_hi = '0;
    logic [31:0] acc_lo = '0;
    logic        swap_b = 1'b0;
    logic        sub_mode = 1'b0;
    logic        long_mode = 1'b0;
    logic        acc_en = 1'b0;
    logic        out_valid;
    logic [31:0] res_hi;
    logic [31:0] res_lo;
    logic        q_flag;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // Expected state for the coming compare.
    logic        exp_v = 1'b0;
    logic [31:0] exp_hi = '0;
    logic [31:0] exp_lo = '0;
    logic        exp_q = 1'b0;
    string       tag_res = "R12";
    string       tag_q = "R12";

    always #5 clk = ~clk;

    dmac_dual16 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .acc_hi    (acc_hi),
        .acc_lo    (acc_lo),
        .swap_b    (swap_b),
        .sub_mode  (sub_mode),
        .long_mode (long_mode),
        .acc_en    (acc_en),
        .out_valid (out_valid),
        .res_hi    (res_hi),
        .res_lo    (res_lo),
        .q_flag    (q_flag)
    );

    // Behavioural reference using 64-bit integers.
    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [31:0] ahi, input logic [31:0] alo,
                                  input logic sw, input logic sb, input logic lg,
                                  input logic ae, output logic [31:0] hi,
                                  output logic [31:0] lo, output logic q);
        logic [31:0] bb;
        longint p1, p2, r, w, t;
        longint maxv, minv;
        maxv = 64'sd2147483647;
        minv = -maxv - 64'sd1;
        bb = sw ? {b[15:0], b[31:16]} : b;
        p1 = longint'($signed(a[15:0])) * longint'($signed(bb[15:0]));
        p2 = longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
        r = sb ? (p1 - p2) : (p1 + p2);
        q = 1'b0;
        if (lg) begin
            if (ae) r = r + longint'($signed({ahi, alo}));
            hi = r[63:32];
            lo = r[31:0];
        end else begin
            if (!sb && (r > maxv || r < minv)) q = 1'b1;
            w = longint'($signed(r[31:0]));
            if (ae) begin
                t = w + longint'($signed(alo));
                if (t > maxv || t < minv) q = 1'b1;
                w = longint'($signed(t[31:0]));
            end
            lo = w[31:0];
            hi = {32{w[31]}};
        end
    endfunction

    task automatic check_outputs();
        compared++;
        if (out_valid !== exp_v) begin
            mismatched++;
            $display("FAIL R11 out_valid actual=%0b expected=%0b", out_valid, exp_v);
        end
        compared++;
        if (res_hi !== exp_hi || res_lo !== exp_lo) begin
            mismatched++;
            $display("FAIL %s result actual=%08h_%08h expected=%08h_%08h",
                     tag_res, res_hi, res_lo, exp_hi, exp_lo);
        end
        compared++;
        if (q_flag !== exp_q) begin
            mismatched++;
            $display("FAIL %s q_flag actual=%0b expected=%0b", tag_q, q_flag, exp_q);
        end
    endtask

    // One clock: compare what the last edge produced, then drive the next input.
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] ahi, input logic [31:0] alo,
                        input logic sw, input logic sb, input logic lg,
                        input logic ae, input string tr);
        @(negedge clk);
        check_outputs();
        in_valid  = v;
        op_a      = a;
        op_b      = b;
        acc_hi    = ahi;
        acc_lo    = alo;
        swap_b    = sw;
        sub_mode  = sb;
        long_mode = lg;
        acc_en    = ae;
        exp_v     = v;
        if (v) begin
            model(a, b, ahi, alo, sw, sb, lg, ae, exp_hi, exp_lo, exp_q);
            tag_res = tr;
            tag_q   = lg ? "R6" : (sb ? "R8" : "R7");
            if (!lg && ae) tag_q = "R9";
        end else begin
            tag_res = "R12";
            tag_q   = "R12";
        end
    endtask

    task automatic idle();
        step(1'b0, $urandom, $urandom, $urandom, $urandom, 1'b1, 1'b1, 1'b0, 1'b1, "R12");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs during and right after reset
        check_outputs();
        rst_n = 1'b1;
        idle();

        // R3: two products of 0x40000000 in long mode stay positive
        step(1, 32'h8000_8000, 32'h8000_8000, 0, 0, 0, 0, 1, 0, "R3");
        // R7, R10: same operands in short add mode overflow
        step(1, 32'h8000_8000, 32'h8000_8000, 0, 0, 0, 0, 0, 0, "R10");
        // R6, R4: long subtract of extremes
        step(1, 32'h8000_7FFF, 32'h7FFF_8000, 0, 0, 0, 1, 1, 0, "R4");
        // R8: short subtract at extremes never flags
        step(1, 32'h8000_8000, 32'h7FFF_8000, 0, 0, 0, 1, 0, 0, "R4");
        idle();
        // R1, R2: asymmetric halves, without then with swap
        step(1, 32'h0003_FFFE, 32'h0005_0007, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 32'h0003_FFFE, 32'h0005_0007, 0, 0, 1, 0, 0, 0, "R1");
        step(1, 32'h1234_8001, 32'hFF00_0100, 0, 0, 1, 0, 1, 0, "R1");
        // R5: long accumulate with negative high word, and acc ignored when disabled
        step(1, 32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 1, 1, "R5");
        step(1, 32'h0002_0003, 32'h0004_0005, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 1, 0, "R5");
        step(1, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 1, 1, 1, "R5");
        // R9: short accumulate overflowing, acc_hi ignored
        step(1, 32'h4000_0000, 32'h0001_0000, 32'hFFFF_FFFF, 32'h7FFF_FFF0, 0, 0, 0, 1, "R9");
        step(1, 32'h0000_8000, 32'h0000_8000, 32'h1111_1111, 32'hC000_0000, 0, 1, 0, 1, "R9");
        step(1, 32'h0000_0001, 32'h0000_0002, 32'hAAAA_AAAA, 32'h8000_0000, 0, 1, 0, 1, "R9");
        idle();
        idle();

        // R11, R12: mixed random traffic with idle gaps
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (($urandom % 4) == 0) a = {a[31] ? 16'h8000 : 16'h7FFF, a[15] ? 16'h8000 : 16'h7FFF};
            if (($urandom % 4) == 0) b = {b[31] ? 16'h8000 : 16'h7FFF, b[15] ? 16'h8000 : 16'h7FFF};
            if (($urandom % 3) == 0) begin
                idle();
            end else begin
                step(1, a, b, $urandom, $urandom, 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), "R2");
            end
        end
        idle();
        @(negedge clk);
        check_outputs();
        summary();
    end

    initial begin
        #(10 * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule